// File: doc/BRIEF.md
# Hub Port Fault Guard

This block guards a single repeater hub port against two kinds of misbehaviour. It sees the port's receive carrier, a strobe for each collision the port takes part in, and a strobe for each piece of valid (collision-free) activity the port produces. From these it drives two gates for the forwarding logic: one that allows the port's received traffic into the repeater, and one that allows traffic from other ports out to this port. It also drives a two-bit fault code for status display.

An overlong receive stream puts the port into jabber shutdown. In that state both directions are closed, and the state lasts until the stream stops. A run of consecutive collisions beyond a limit partitions the port. In that state only the receive direction is closed, and the state lasts until the port shows valid activity. One cycle of the 25 MHz nibble clock carries four bit times, so the default jabber limit of 16,384 cycles equals 65,536 bit times. The gates and the fault code come straight from registered state, so each one changes at the clock edge that samples its cause. All pins are plain level or strobe controls. No data passes through the block, so it has no handshake.

Top module: `port_guard`

## Requirements
- R1: After reset, and after any later reset, rx_enable = 1, tx_enable = 1, fault_code = 2'b00, and both counters are cleared.
- R2: If rx_active is sampled high on more than JABBER_CYCLES (default 16384) consecutive edges, the edge that samples it for the (JABBER_CYCLES+1)-th time enters jabber shutdown. In that state rx_enable = 0, tx_enable = 0 and fault_code = 2'b10.
- R3: The first edge that samples rx_active low ends jabber shutdown at that same edge. A single low sample restarts the jabber count from zero.
- R4: Each edge that samples coll_hit high counts one collision. The edge that counts the (PART_LIMIT+1)-th consecutive collision (default the 61st) partitions the port. In that state, with no jabber, rx_enable = 0, tx_enable = 1 and fault_code = 2'b01.
- R5: A receive event is a run of high rx_active samples. If an event ends (rx_active falls) with no coll_hit since the previous event end, the collision count returns to zero.
- R6: A valid_seen strobe without coll_hit on the same edge clears both the partition and the collision count. The end of a clean event clears only the count and leaves the partition in place.
- R7: When coll_hit and valid_seen are high on the same edge, the collision is counted and the valid strobe is ignored.
- R8: When jabber and partition hold together, jabber takes priority: fault_code = 2'b10 and both enables are 0. When the jabber ends, the partition gating (2'b01) remains.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Nibble clock (25 MHz in the system) |
| rst_n | input | 1 | Active-low reset; clears all state |
| rx_active | input | 1 | Receive carrier present on the port |
| coll_hit | input | 1 | One-cycle strobe: the port took part in a collision |
| valid_seen | input | 1 | One-cycle strobe: valid activity seen on the port |
| rx_enable | output | 1 | Port's received traffic may enter the repeater |
| tx_enable | output | 1 | Traffic from other ports may be sent to this port |
| fault_code | output | 2 | 00 none, 01 partitioned, 10 jabber |

## Verification
The assertions check, on every cycle, the local cause-and-effect rules. A low carrier sample clears jabber at the next edge. A partition can only appear after a counted collision. A clean valid strobe lifts the partition. The collision count never passes its saturation value. The gates always agree with the fault code. Only the bench's scenarios can show the exact thresholds: no fault after 16,384 active cycles or 60 collisions, and a fault one sample later. The same holds for the counter restart after a one-cycle carrier gap, the count reset by a clean event, the collision winning over a same-cycle valid strobe, and the jabber priority over a partition.

// File: rtl/port_guard_pkg.sv
package port_guard_pkg;

  typedef enum logic [1:0] {
    FLT_NONE = 2'b00,
    FLT_PART = 2'b01,
    FLT_JAB  = 2'b10
  } fault_e;

endpackage

// File: rtl/jabber_timer.sv
module jabber_timer #(
  parameter int LIMIT = 16384
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rx_active,
  output logic jabber
);
  localparam int CW = $clog2(LIMIT + 1);
  localparam logic [CW-1:0] LIM_C = CW'(LIMIT);

  logic [CW-1:0] run_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_cnt <= '0;
      jabber  <= 1'b0;
    end else if (!rx_active) begin
      run_cnt <= '0;
      jabber  <= 1'b0;
    end else if (run_cnt == LIM_C) begin
      jabber  <= 1'b1;
    end else begin
      run_cnt <= run_cnt + 1'b1;
    end
  end

  // R3: a low carrier sample always ends shutdown
  assert_jab_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_active |=> !jabber);

  // R2: shutdown only begins while the carrier is still up
  assert_jab_entry_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(jabber) |-> $past(rx_active));

endmodule

// File: rtl/collision_tracker.sv
module collision_tracker #(
  parameter int LIMIT = 60
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rx_active,
  input  logic coll_hit,
  input  logic valid_seen,
  output logic partitioned
);
  localparam int CW = $clog2(LIMIT + 2);
  localparam logic [CW-1:0] LIM_C = CW'(LIMIT);
  localparam logic [CW-1:0] SAT_C = CW'(LIMIT + 1);

  logic [CW-1:0] coll_cnt;
  logic          rx_prev;
  logic          coll_seen;
  logic          event_end;

  assign event_end = rx_prev & ~rx_active;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      coll_cnt    <= '0;
      rx_prev     <= 1'b0;
      coll_seen   <= 1'b0;
      partitioned <= 1'b0;
    end else begin
      rx_prev <= rx_active;
      if (coll_hit) begin
        if (coll_cnt != SAT_C) coll_cnt <= coll_cnt + 1'b1;
        if (coll_cnt >= LIM_C) partitioned <= 1'b1;
        coll_seen <= ~event_end;
      end else begin
        if (valid_seen) begin
          coll_cnt    <= '0;
          partitioned <= 1'b0;
        end else if (event_end && !coll_seen) begin
          coll_cnt <= '0;
        end
        if (event_end) coll_seen <= 1'b0;
      end
    end
  end

  // R4: partition is entered only on a counted collision
  assert_part_entry_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(partitioned) |-> $past(coll_hit));

  // R6: a clean valid strobe lifts the partition
  assert_part_exit_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_seen && !coll_hit) |=> !partitioned);

  // R7: a collision on the same edge keeps a partition in place
  assert_coll_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (partitioned && coll_hit) |=> partitioned);

  assert_cnt_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
    coll_cnt <= SAT_C);

endmodule

// File: rtl/port_gate.sv
module port_gate
  import port_guard_pkg::*;
(
  input  logic       jabber,
  input  logic       partitioned,
  output logic       rx_enable,
  output logic       tx_enable,
  output logic [1:0] fault_code
);
  fault_e code;

  always_comb begin
    if (jabber)           code = FLT_JAB;
    else if (partitioned) code = FLT_PART;
    else                  code = FLT_NONE;
  end

  assign fault_code = code;
  assign tx_enable  = (code != FLT_JAB);
  assign rx_enable  = (code == FLT_NONE);

endmodule

// File: rtl/port_guard.sv
module port_guard #(
  parameter int JABBER_CYCLES = 16384,
  parameter int PART_LIMIT    = 60
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rx_active,
  input  logic       coll_hit,
  input  logic       valid_seen,
  output logic       rx_enable,
  output logic       tx_enable,
  output logic [1:0] fault_code
);
  logic jabber;
  logic partitioned;

  jabber_timer #(.LIMIT(JABBER_CYCLES)) u_jab (
    .clk       (clk),
    .rst_n     (rst_n),
    .rx_active (rx_active),
    .jabber    (jabber)
  );

  collision_tracker #(.LIMIT(PART_LIMIT)) u_coll (
    .clk         (clk),
    .rst_n       (rst_n),
    .rx_active   (rx_active),
    .coll_hit    (coll_hit),
    .valid_seen  (valid_seen),
    .partitioned (partitioned)
  );

  port_gate u_gate (
    .jabber      (jabber),
    .partitioned (partitioned),
    .rx_enable   (rx_enable),
    .tx_enable   (tx_enable),
    .fault_code  (fault_code)
  );

  // R8: jabber closes both directions whatever the partition state
  assert_jab_priority_R8: assert property (@(posedge clk) disable iff (!rst_n)
    jabber |-> (!tx_enable && !rx_enable && fault_code == 2'b10));

  // R4: a partition alone keeps the transmit direction open
  assert_part_gate_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (partitioned && !jabber) |-> (tx_enable && !rx_enable));

  // R1: the code never shows both faults at once
  assert_code_onehot_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(fault_code));

endmodule

// File: tb/test_port_guard.sv
module test_port_guard;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rx_active = 1'b0;
  logic       coll_hit = 1'b0;
  logic       valid_seen = 1'b0;
  logic       rx_enable;
  logic       tx_enable;
  logic [1:0] fault_code;

  int n_chk = 0;
  int n_bad = 0;

  localparam int JL = 16384;
  localparam int PL = 60;

  always #10 clk = ~clk;

  port_guard i_port_guard (
    .clk(clk), .rst_n(rst_n), .rx_active(rx_active), .coll_hit(coll_hit),
    .valid_seen(valid_seen), .rx_enable(rx_enable), .tx_enable(tx_enable),
    .fault_code(fault_code)
  );

  // fields: [6] rx, [5] coll, [4] valid, [3] exp rx_en, [2] exp tx_en, [1:0] exp code
  localparam logic [6:0] TBL [0:7] = '{
    7'b100_11_00,  // R1 plain event start
    7'b110_11_00,  // R4 single collision, no partition
    7'b000_11_00,
    7'b001_11_00,  // R6 valid while healthy
    7'b100_11_00,
    7'b000_11_00,  // R5 clean event end
    7'b011_11_00,  // R7 coll+valid together
    7'b000_11_00
  };

  task automatic step(input logic r, input logic c, input logic v);
    @(negedge clk);
    rx_active = r; coll_hit = c; valid_seen = v;
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string tag, input logic erx, input logic etx, input logic [1:0] ec);
    n_chk++;
    if (rx_enable !== erx || tx_enable !== etx || fault_code !== ec) begin
      n_bad++;
      $display("FAIL %s: got rx_en=%b tx_en=%b code=%b, expected rx_en=%b tx_en=%b code=%b",
               tag, rx_enable, tx_enable, fault_code, erx, etx, ec);
    end
  endtask

  task automatic coll_events(input int n);
    for (int i = 0; i < n; i++) begin
      step(1'b1, 1'b1, 1'b0);
      step(1'b0, 1'b0, 1'b0);
    end
  endtask

  task automatic hold_rx(input int n);
    for (int i = 0; i < n; i++) step(1'b1, 1'b0, 1'b0);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; rx_active = 1'b0; coll_hit = 1'b0; valid_seen = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    #1;
  endtask

  initial begin
    #4000000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: got no completion, expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    #1;
    chk("R1 reset state", 1'b1, 1'b1, 2'b00);
    rst_n = 1'b1;

    for (int k = 0; k < 8; k++) begin
      step(TBL[k][6], TBL[k][5], TBL[k][4]);
      chk($sformatf("R1 table vector %0d", k), TBL[k][3], TBL[k][2], TBL[k][1:0]);
    end

    do_reset();
    chk("R1 reset again", 1'b1, 1'b1, 2'b00);

    // R4 threshold
    coll_events(PL);
    chk("R4 at limit no partition", 1'b1, 1'b1, 2'b00);
    coll_events(1);
    chk("R4 partition entered", 1'b0, 1'b1, 2'b01);

    // R6 clean event does not lift, valid does
    step(1'b1, 1'b0, 1'b0);
    step(1'b0, 1'b0, 1'b0);
    chk("R6 clean event keeps partition", 1'b0, 1'b1, 2'b01);
    step(1'b0, 1'b0, 1'b1);
    chk("R6 valid lifts partition", 1'b1, 1'b1, 2'b00);

    // R7 collision wins over valid
    coll_events(PL + 1);
    chk("R7 partition re-entered", 1'b0, 1'b1, 2'b01);
    step(1'b0, 1'b1, 1'b1);
    chk("R7 valid ignored with collision", 1'b0, 1'b1, 2'b01);
    step(1'b0, 1'b0, 1'b1);

    // R5 clean event restarts the count
    coll_events(PL);
    step(1'b1, 1'b0, 1'b0);
    step(1'b0, 1'b0, 1'b0);
    coll_events(PL);
    chk("R5 count cleared by clean event", 1'b1, 1'b1, 2'b00);
    coll_events(1);
    chk("R5 partition after fresh run", 1'b0, 1'b1, 2'b01);
    step(1'b0, 1'b0, 1'b1);

    // R2 jabber threshold
    hold_rx(JL);
    chk("R2 at limit no jabber", 1'b1, 1'b1, 2'b00);
    hold_rx(1);
    chk("R2 jabber entered", 1'b0, 1'b0, 2'b10);
    hold_rx(5);
    chk("R2 jabber held", 1'b0, 1'b0, 2'b10);
    step(1'b0, 1'b0, 1'b0);
    chk("R3 jabber ends on carrier drop", 1'b1, 1'b1, 2'b00);

    // R3 one-cycle gap restarts timer
    hold_rx(JL - 400);
    step(1'b0, 1'b0, 1'b0);
    hold_rx(JL - 400);
    chk("R3 timer restarted by gap", 1'b1, 1'b1, 2'b00);
    step(1'b0, 1'b0, 1'b0);

    // R8 priority
    coll_events(PL + 1);
    hold_rx(JL + 1);
    chk("R8 jabber over partition", 1'b0, 1'b0, 2'b10);
    step(1'b0, 1'b0, 1'b0);
    chk("R8 partition remains after jabber", 1'b0, 1'b1, 2'b01);
    step(1'b0, 1'b0, 1'b1);

    // R1 reset mid-fault
    hold_rx(JL + 1);
    chk("R1 jabber before reset", 1'b0, 1'b0, 2'b10);
    do_reset();
    chk("R1 reset clears jabber", 1'b1, 1'b1, 2'b00);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule